// File: doc/BRIEF.md
# Register-Count Barrel Shifter with Extend Flag

This block is the shift unit of a 32-bit integer datapath. It shifts a 32-bit operand left or right, either logically or arithmetically, by an amount taken from a general register. It produces the shifted value together with the negative, zero, overflow, carry and extend condition flags. The carry flag reports the last bit that left the operand. The extend flag follows the carry only when a real shift took place; otherwise it passes the incoming extend value through unchanged.

The operand, count, operation code and incoming extend flag are captured in a single register stage whenever `in_en` is high. The result and flags appear on the next clock edge, and `out_vld` pulses for that one cycle. Only the low six bits of the count are used, so the effective amount runs from 0 to 63. Amounts from 32 upward push every operand bit out of the word.

Top module: `shf32_xflag`

## Requirements
- R1: The effective shift amount is `in_cnt` modulo 64, meaning its low six bits. All higher bits of `in_cnt` have no effect on any output.
- R2: Operation code 2'b00 (and code 2'b10, which behaves identically) is a logical left shift. Zeros enter at bit 0, and an amount of 32 or more gives a zero result. For amounts 1 to 32, C equals operand bit (32 − amount); above 32, C is 0.
- R3: Operation code 2'b01 is a logical right shift. Zeros enter at bit 31. For amounts 1 to 32, C equals operand bit (amount − 1); above 32, C is 0.
- R4: Operation code 2'b11 is an arithmetic right shift. Copies of operand bit 31 enter at the top, so an amount of 32 or more gives 32 copies of the sign. C equals operand bit (amount − 1) for amounts 1 to 32, and equals the sign bit above 32.
- R5: With an effective amount of zero, the result equals the operand and C is 0, for every operation code.
- R6: The X output equals C when the effective amount is nonzero. When the amount is zero, X equals the `in_x` value captured with the operation.
- R7: N equals bit 31 of the result, and Z is 1 exactly when all 32 result bits are zero.
- R8: V is 0 for the logical shifts. For the arithmetic shift, V is set only when the sign of the result differs from the sign of the operand, which a right arithmetic shift never produces, so V reads 0.
- R9: Inputs are captured on a rising edge with `in_en` high. The result and flags update at that same edge, and `out_vld` is high for that one cycle only. While `in_en` is low, all results and flags hold and `out_vld` is 0.
- R10: While reset is asserted, and until the first capture after it, the result, every flag and `out_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_en | input | 1 | Capture strobe for a new shift |
| in_op | input | 2 | Operation: 00 left logical, 01 right logical, 10 left logical, 11 right arithmetic |
| in_cnt | input | 32 | Shift count register value; low six bits used |
| in_opnd | input | 32 | Operand to shift |
| in_x | input | 1 | Current extend flag |
| out_vld | output | 1 | Result and flags updated this cycle |
| out_res | output | 32 | Shifted result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag (last bit shifted out) |
| out_x | output | 1 | Extend flag |

## Verification
Two functions meet in a single cycle when the count register holds a nonzero multiple of 64. The amount reduction turns the shift into a no-op, so the extend retention and the carry clearing must both take effect even though the raw count is nonzero. The bench provokes this with a count of 64 and an incoming extend of 1, and with a large count whose low six bits equal 1. It judges the result, C and X together against the zero-amount and single-bit expectations. A second overlap, where the sign fill and the carry both come from bit 31 on an arithmetic shift past 32, is checked with a negative operand.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    OP_LSL   = 2'b00,
    OP_LSR   = 2'b01,
    OP_LSL_B = 2'b10,
    OP_ASR   = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shf_barrel.sv
// Logarithmic right shifter over a double-width window with a fill bit.
module shf_barrel #(
  parameter int WIN_W = 64,
  parameter int AMT_W = 6
) (
  input  logic [WIN_W-1:0] win_in,
  input  logic             fill,
  input  logic [AMT_W-1:0] amt,
  output logic [WIN_W-1:0] win_out
);
  logic [WIN_W-1:0] stg [AMT_W+1];

  assign stg[0] = win_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][WIN_W-1:STEP]} : stg[k];
  end

  assign win_out = stg[AMT_W];
endmodule

// File: rtl/shf_core.sv
// Shift datapath: left shifts reuse the right shifter through bit reversal.
module shf_core
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(2 * W)
) (
  input  logic [W-1:0]     opnd,
  input  logic [AMT_W-1:0] amt,
  input  shift_op_e        op,
  output logic [W-1:0]     res,
  output logic             c_bit,
  output logic             v_bit
);
  localparam int WIN_W = 2 * W;

  logic             go_right;
  logic             arith;
  logic [W-1:0]     opnd_rev;
  logic [W-1:0]     hi_rev;
  logic [WIN_W-1:0] win_in;
  logic [WIN_W-1:0] win_out;
  logic             fill;

  assign go_right = op[0];
  assign arith    = (op == OP_ASR);
  assign fill     = arith & opnd[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign opnd_rev[i] = opnd[W-1-i];
    assign hi_rev[i]   = win_out[WIN_W-1-i];
  end

  assign win_in = {(go_right ? opnd : opnd_rev), {W{1'b0}}};

  shf_barrel #(.WIN_W(WIN_W), .AMT_W(AMT_W)) u_barrel (
    .win_in  (win_in),
    .fill    (fill),
    .amt     (amt),
    .win_out (win_out)
  );

  always_comb begin
    res   = go_right ? win_out[WIN_W-1:W] : hi_rev;
    c_bit = (amt != '0) ? win_out[W-1] : 1'b0;
    v_bit = arith & (res[W-1] ^ opnd[W-1]);
  end
endmodule

// File: rtl/shf_flags.sv
// Condition flag formation from the shifted value.
module shf_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         c_bit,
  input  logic         v_bit,
  input  logic         amt_nz,
  input  logic         x_in,
  output logic [4:0]   nzvcx
);
  always_comb begin
    nzvcx[4] = res[W-1];
    nzvcx[3] = (res == '0);
    nzvcx[2] = v_bit;
    nzvcx[1] = c_bit;
    nzvcx[0] = amt_nz ? c_bit : x_in;
  end
endmodule

// File: rtl/shf32_xflag.sv
module shf32_xflag
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [1:0]       in_op,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [W-1:0]     in_opnd,
  input  logic             in_x,
  output logic             out_vld,
  output logic [W-1:0]     out_res,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_c,
  output logic             out_x
);
  localparam int AMT_W = $clog2(2 * W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [AMT_W-1:0] amt;
  logic             unused_cnt_hi;
  assign amt           = in_cnt[AMT_W-1:0];
  assign unused_cnt_hi = ^in_cnt[CNT_W-1:AMT_W];

  logic [W-1:0] core_res;
  logic         core_c;
  logic         core_v;
  logic [4:0]   core_flags;

  shf_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .opnd  (in_opnd),
    .amt   (amt),
    .op    (shift_op_e'(in_op)),
    .res   (core_res),
    .c_bit (core_c),
    .v_bit (core_v)
  );

  shf_flags #(.W(W)) u_flags (
    .res    (core_res),
    .c_bit  (core_c),
    .v_bit  (core_v),
    .amt_nz (amt != '0),
    .x_in   (in_x),
    .nzvcx  (core_flags)
  );

  // next state
  logic [W-1:0] res_q, res_d;
  logic [4:0]   flg_q, flg_d;
  logic         vld_q, vld_d;

  always_comb begin
    vld_d = in_en;
    res_d = res_q;
    flg_d = flg_q;
    if (in_en) begin
      res_d = core_res;
      flg_d = core_flags;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
      vld_q <= vld_d;
    end
  end

  assign out_vld = vld_q;
  assign out_res = res_q;
  assign out_n   = flg_q[4];
  assign out_z   = flg_q[3];
  assign out_v   = flg_q[2];
  assign out_c   = flg_q[1];
  assign out_x   = flg_q[0];

  // R5
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && in_en && amt == '0 |=> out_res == $past(in_opnd) && !out_c);

  // R6
  x_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && in_en && amt == '0 |=> out_x == $past(in_x));

  // R8
  logic_v_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && in_en && in_op != OP_ASR |=> !out_v);

  // R2
  lsl_flush_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && in_en && !in_op[0] && amt >= AMT_W'(W) |=> out_res == '0);

  // R7
  zero_opnd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && in_en && in_opnd == '0 |=> out_z && !out_n);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_int_n && !in_en |=> $stable(out_res) && $stable(out_x) && !out_vld);
endmodule

// File: tb/sim_shf32_xflag.sv
module sim_shf32_xflag;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_en;
  logic [1:0]  in_op;
  logic [31:0] in_cnt;
  logic [31:0] in_opnd;
  logic        in_x;
  logic        out_vld;
  logic [31:0] out_res;
  logic        out_n, out_z, out_v, out_c, out_x;

  always #10 clk = ~clk;  // 50 MHz

  shf32_xflag u0 (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_op(in_op), .in_cnt(in_cnt),
    .in_opnd(in_opnd), .in_x(in_x), .out_vld(out_vld), .out_res(out_res),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c), .out_x(out_x)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // {op[2], cnt[32], opnd[32], x[1], res[32], flags n z v c x[5], req[4]}
  localparam int NV = 17;
  localparam logic [107:0] VEC [NV] = '{
    {2'b00, 32'd4,  32'h8000_0001, 1'b0, 32'h0000_0010, 5'b00000, 4'd2},  // R2
    {2'b00, 32'd1,  32'h8000_0001, 1'b0, 32'h0000_0002, 5'b00011, 4'd2},  // R2 R6
    {2'b00, 32'd32, 32'h0000_0001, 1'b0, 32'h0000_0000, 5'b01011, 4'd2},  // R2 R7
    {2'b00, 32'd40, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 5'b01000, 4'd2},  // R2 R6
    {2'b01, 32'd1,  32'h0000_0003, 1'b0, 32'h0000_0001, 5'b00011, 4'd3},  // R3
    {2'b01, 32'd31, 32'h8000_0000, 1'b0, 32'h0000_0001, 5'b00000, 4'd3},  // R3
    {2'b01, 32'd32, 32'h8000_0000, 1'b0, 32'h0000_0000, 5'b01011, 4'd3},  // R3
    {2'b01, 32'd63, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 5'b01000, 4'd3},  // R3
    {2'b11, 32'd4,  32'h8000_0010, 1'b0, 32'hF800_0001, 5'b10000, 4'd4},  // R4
    {2'b11, 32'd5,  32'h8000_0010, 1'b0, 32'hFC00_0000, 5'b10011, 4'd4},  // R4
    {2'b11, 32'd33, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 5'b10011, 4'd4},  // R4
    {2'b11, 32'd40, 32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 5'b01000, 4'd8},  // R8 R4
    {2'b11, 32'd0,  32'h8000_0000, 1'b1, 32'h8000_0000, 5'b10001, 4'd5},  // R5 R6
    {2'b00, 32'd64, 32'h1234_5678, 1'b1, 32'h1234_5678, 5'b00001, 4'd1},  // R1
    {2'b01, 32'hFFFF_FF81, 32'h0000_0002, 1'b0, 32'h0000_0001, 5'b00000, 4'd1},  // R1
    {2'b10, 32'd4,  32'h1234_5678, 1'b0, 32'h2345_6780, 5'b00011, 4'd2},  // R2 alias code
    {2'b00, 32'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 5'b01000, 4'd7}   // R7 R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] cnt,
                        input logic [31:0] opnd, input logic x);
    @(negedge clk);
    in_op = op; in_cnt = cnt; in_opnd = opnd; in_x = x; in_en = 1'b1;
    @(negedge clk);
    in_en = 1'b0;
  endtask

  function automatic logic [31:0] flags();
    return {27'd0, out_n, out_z, out_v, out_c, out_x};
  endfunction

  initial begin
    rst_n = 1'b0; in_en = 1'b0; in_op = 2'b00; in_cnt = '0; in_opnd = '0; in_x = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 res", out_res, 32'h0);
    chk("R10 flags", flags(), 32'h0);
    chk("R10 vld", {31'd0, out_vld}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release", {out_res[30:0], out_vld}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      v = VEC[i];
      run_op(v[107:106], v[105:74], v[73:42], v[41]);
      chk($sformatf("R%0d vec%0d res", v[3:0], i), out_res, v[40:9]);
      chk($sformatf("R%0d vec%0d nzvcx", v[3:0], i), flags(), {27'd0, v[8:4]});
      chk($sformatf("R9 vec%0d vld", i), {31'd0, out_vld}, 32'h1);
    end

    // R9 hold: change inputs with strobe low, outputs must not move
    run_op(2'b11, 32'd5, 32'h8000_0010, 1'b0);   // result FC000000, flags 10011
    @(negedge clk);
    in_op = 2'b00; in_cnt = 32'd0; in_opnd = 32'h0; in_x = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold res", out_res, 32'hFC00_0000);
    chk("R9 hold flags", flags(), 32'h13);
    chk("R9 vld low", {31'd0, out_vld}, 32'h0);

    // R1 R6 coincidence: big count, low bits zero, X in = 1
    run_op(2'b11, 32'h0000_1040, 32'hC000_0001, 1'b1);
    chk("R1 big count res", out_res, 32'hC000_0001);
    chk("R6 big count nzvcx", flags(), 32'h11);

    // R8 arithmetic shift of a negative value keeps V clear
    run_op(2'b11, 32'd31, 32'h8000_0000, 1'b0);
    chk("R8 asr res", out_res, 32'hFFFF_FFFF);
    chk("R8 asr nzvcx", flags(), 32'h10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule